// File: doc/BRIEF.md
# Oversampled Serial Receiver with Sticky Overrun

This block receives asynchronous serial words of one start bit, `DATA_W` data bits sent least significant bit first, and one stop bit. The serial input first passes through a two-stage synchroniser. It is then sampled `OSR` times per bit. A sample strobe is produced every `SAMPLE_DIV` clocks. Each word with a valid stop bit goes into a small first-in first-out buffer. The host reads that buffer through a first-word-fall-through port: `rd_data` always shows the oldest word, and a one-cycle `rd_en` pulse removes it.

Three status outputs describe the receiver:
- `data_rdy`: the buffer holds at least one word.
- `line_idle`: the line has stayed high for `IDLE_BITS` bit times after a stored word.
- `overrun`: a word arrived while the buffer was full, and that word was lost.

Overrun is sticky. While it is set, the receiver stores no word, even if the host frees space. Words received during this time cannot raise `data_rdy` or `line_idle`. Flags that were already set stay set. The host clears `overrun` and `line_idle` with one-cycle clear pulses.

The frame state machine has five states:
- `RX_IDLE` waits for a low sample and moves to `RX_START`.
- `RX_START` re-checks the line at mid start bit. It returns to `RX_IDLE` on a false start, or moves to `RX_DATA`.
- `RX_DATA` samples each bit centre. After the last data bit it moves to `RX_STOP`.
- `RX_STOP` checks the stop bit. If the line is high, it reports the word and returns to `RX_IDLE`. If the line is low, it moves to `RX_WAIT_HIGH`.
- `RX_WAIT_HIGH` waits for a high sample and then returns to `RX_IDLE`.

Top module: `uart_rx_ovr`

## Requirements
- R1: A low pulse on `rx_in` that is shorter than half a bit time is rejected at the mid start-bit check and stores no word.
- R2: The data bits are taken least significant bit first, each sampled at its centre. `rd_data` equals the transmitted byte for every 8-bit value.
- R3: A frame whose stop bit is low is discarded. It does not raise `data_rdy`, `overrun` or `line_idle`.
- R4: `data_rdy` is high exactly when the buffer is not empty. Words are read out in arrival order, and a read that empties the buffer drops `data_rdy`.
- R5: When a valid word arrives and the buffer already holds `DEPTH` words, `overrun` is set and that word is lost.
- R6: While `overrun` is set, no word is stored, even after reads have freed space, and `overrun` stays set until `clr_ovr`.
- R7: While `overrun` is set, received words do not newly assert `data_rdy` or `line_idle`.
- R8: A `data_rdy` or `line_idle` that was high when the overrun occurred stays high until it is cleared by reads or by `clr_idle`.
- R9: `line_idle` rises after `IDLE_BITS` bit times of high line that follow a stored word. `clr_idle` drops it, and it does not rise again until another word is stored.
- R10: A `clr_ovr` pulse clears `overrun`, and the next valid word is stored normally.
- R11: After reset, `data_rdy`, `line_idle` and `overrun` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_in | input | 1 | Asynchronous serial line, idles high |
| rd_en | input | 1 | Pops the oldest buffered word |
| rd_data | output | DATA_W | Oldest buffered word |
| data_rdy | output | 1 | Buffer holds at least one word |
| line_idle | output | 1 | Idle line seen after a stored word |
| overrun | output | 1 | Word lost to a full buffer (sticky) |
| clr_idle | input | 1 | Clears `line_idle` |
| clr_ovr | input | 1 | Clears `overrun` |

## Verification
The data path is swept over all 256 byte values in back-to-back frames. This separates bit-order and bit-centre errors from buffer-order errors. A short low glitch and a frame with a low stop bit show that the start check and the stop check each reject on their own. A three-word burst into the two-entry buffer, followed by reads, further words during overrun, flag clears and a final word, shows the difference between storing while overrun is set, gating the flags, and losing a flag that was already set. Idle timing is checked both before and after `clr_idle`, which shows whether the idle detector re-arms.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_WAIT_HIGH
    } rx_state_e;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], din};
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/rx_framer.sv
module rx_framer
    import uart_rx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int OSR        = 16,
    parameter int SAMPLE_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line,
    output logic              tick,
    output logic              word_done,
    output logic [DATA_W-1:0] word
);
    localparam int SW   = $clog2(OSR);
    localparam int DVW  = $clog2(SAMPLE_DIV);
    localparam int BW   = $clog2(DATA_W);
    localparam int HALF = OSR / 2;

    rx_state_e         state, nxt;
    logic [DVW-1:0]    div_cnt;
    logic [SW-1:0]     smp_cnt;
    logic [BW-1:0]     bit_idx;
    logic [DATA_W-1:0] shreg;
    logic              bit_end;

    // sample strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                div_cnt <= '0;
        else if (div_cnt == DVW'(SAMPLE_DIV - 1)) div_cnt <= '0;
        else                                       div_cnt <= div_cnt + 1'b1;
    end
    assign tick    = (div_cnt == DVW'(SAMPLE_DIV - 1));
    assign bit_end = tick && (smp_cnt == SW'(OSR - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            RX_IDLE:      if (tick && !line) nxt = RX_START;
            RX_START:     if (tick && smp_cnt == SW'(HALF - 1))
                              nxt = line ? RX_IDLE : RX_DATA;
            RX_DATA:      if (bit_end && bit_idx == BW'(DATA_W - 1)) nxt = RX_STOP;
            RX_STOP:      if (bit_end) nxt = line ? RX_IDLE : RX_WAIT_HIGH;
            RX_WAIT_HIGH: if (tick && line) nxt = RX_IDLE;
            default:      nxt = RX_IDLE;
        endcase
    end

    // sample counters and shift register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_cnt <= '0;
            bit_idx <= '0;
            shreg   <= '0;
        end else if (nxt != state) begin
            smp_cnt <= '0;
            if (state == RX_DATA) shreg <= {line, shreg[DATA_W-1:1]};
            if (nxt == RX_DATA)   bit_idx <= '0;
        end else if (tick && state != RX_IDLE && state != RX_WAIT_HIGH) begin
            if (bit_end) begin
                smp_cnt <= '0;
                if (state == RX_DATA) begin
                    shreg   <= {line, shreg[DATA_W-1:1]};
                    bit_idx <= bit_idx + 1'b1;
                end
            end else begin
                smp_cnt <= smp_cnt + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        word_done = (state == RX_STOP) && bit_end && line;
        word      = shreg;
    end

    // R1: data phase is only entered through a validated start bit
    p_data_from_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_DATA && $past(state) != RX_DATA) |-> $past(state) == RX_START);

    // R3: a word is reported only out of the stop state
    p_done_in_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |=> state == RX_IDLE);
endmodule

// File: rtl/rx_buffer.sv
module rx_buffer #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] din,
    input  logic              pop,
    output logic [DATA_W-1:0] dout,
    output logic              empty,
    output logic              full
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr, rd_ptr;
    logic [CW-1:0]     count;
    logic              do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push)
                wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)
                rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // R5: the storage is never written past its depth
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
endmodule

// File: rtl/uart_rx_ovr.sv
module uart_rx_ovr #(
    parameter int DATA_W     = 8,
    parameter int OSR        = 16,
    parameter int SAMPLE_DIV = 2,
    parameter int DEPTH      = 2,
    parameter int IDLE_BITS  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_in,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              data_rdy,
    output logic              line_idle,
    output logic              overrun,
    input  logic              clr_idle,
    input  logic              clr_ovr
);
    localparam int IDLE_SMP = IDLE_BITS * OSR;
    localparam int IW       = $clog2(IDLE_SMP + 1);

    logic              line_s, tick, word_done;
    logic [DATA_W-1:0] word;
    logic              buf_empty, buf_full, store, lose;
    logic              ovr_q, idle_q, armed_q, idle_fire;
    logic [IW-1:0]     high_cnt;

    rx_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(rx_in), .dout(line_s)
    );

    rx_framer #(.DATA_W(DATA_W), .OSR(OSR), .SAMPLE_DIV(SAMPLE_DIV)) u_framer (
        .clk(clk), .rst_n(rst_n), .line(line_s), .tick(tick),
        .word_done(word_done), .word(word)
    );

    assign store = word_done && !ovr_q && !buf_full;
    assign lose  = word_done && !ovr_q && buf_full;

    rx_buffer #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_buf (
        .clk(clk), .rst_n(rst_n), .push(store), .din(word),
        .pop(rd_en), .dout(rd_data), .empty(buf_empty), .full(buf_full)
    );

    // sticky overrun: setting wins over a coincident clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ovr_q <= 1'b0;
        else if (lose)    ovr_q <= 1'b1;
        else if (clr_ovr) ovr_q <= 1'b0;
    end

    // idle-line detector, armed only by a stored word
    assign idle_fire = armed_q && tick && line_s && (high_cnt == IW'(IDLE_SMP - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            high_cnt <= '0;
            armed_q  <= 1'b0;
            idle_q   <= 1'b0;
        end else begin
            if (word_done)                       high_cnt <= '0;
            else if (tick && !line_s)            high_cnt <= '0;
            else if (tick && high_cnt != IW'(IDLE_SMP)) high_cnt <= high_cnt + 1'b1;

            if (store)          armed_q <= 1'b1;
            else if (idle_fire) armed_q <= 1'b0;

            if (idle_fire && !ovr_q) idle_q <= 1'b1;
            else if (clr_idle)       idle_q <= 1'b0;
        end
    end

    assign data_rdy  = !buf_empty;
    assign line_idle = idle_q;
    assign overrun   = ovr_q;

    // R6: overrun holds until cleared
    p_ovr_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !clr_ovr) |=> overrun);
    // R7: data-ready cannot newly rise during overrun
    p_rdy_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !clr_ovr && !data_rdy) |=> !data_rdy);
    // R7: idle cannot newly rise during overrun
    p_idle_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !clr_ovr && !line_idle) |=> !line_idle);
    // R8: idle stays set until its clear
    p_idle_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (line_idle && !clr_idle) |=> line_idle);
    // R8: buffered data survives an overrun until read
    p_rdy_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rdy && !rd_en) |=> data_rdy);
endmodule

// File: tb/uart_rx_ovr_tb.sv
module uart_rx_ovr_tb;
    localparam int CLK_PERIOD = 10;
    localparam int OSR        = 16;
    localparam int SAMPLE_DIV = 2;
    localparam int BIT        = OSR * SAMPLE_DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_in = 1'b1;
    logic       rd_en = 1'b0;
    logic       clr_idle = 1'b0;
    logic       clr_ovr = 1'b0;
    logic [7:0] rd_data;
    logic       data_rdy, line_idle, overrun;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    uart_rx_ovr #(.DATA_W(8), .OSR(OSR), .SAMPLE_DIV(SAMPLE_DIV),
                  .DEPTH(2), .IDLE_BITS(10)) u_dut (
        .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .rd_en(rd_en),
        .rd_data(rd_data), .data_rdy(data_rdy), .line_idle(line_idle),
        .overrun(overrun), .clr_idle(clr_idle), .clr_ovr(clr_ovr)
    );

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic wait_bits(input int n);
        repeat (n * BIT) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] v, input logic stop);
        rx_in = 1'b0;
        wait_bits(1);
        for (int i = 0; i < 8; i++) begin
            rx_in = v[i];
            wait_bits(1);
        end
        rx_in = stop;
        wait_bits(1);
        rx_in = 1'b1;
    endtask

    task automatic pulse(input int which);
        if (which == 0) rd_en = 1'b1;
        else if (which == 1) clr_idle = 1'b1;
        else clr_ovr = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        clr_idle = 1'b0;
        clr_ovr = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL R11 watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 data_rdy at reset", 32'(data_rdy), 0);
        check("R11 line_idle at reset", 32'(line_idle), 0);
        check("R11 overrun at reset", 32'(overrun), 0);

        // R2 / R4: sweep every byte value
        for (int b = 0; b < 256; b++) begin
            logic [7:0] v;
            v = 8'(b);
            send(v, 1'b1);
            wait_bits(1);
            check("R4 data_rdy after word", 32'(data_rdy), 1);
            check("R2 received byte", 32'(rd_data), 32'(v));
            pulse(0);
            check("R4 data_rdy after read", 32'(data_rdy), 0);
        end
        wait_bits(12);
        check("R9 idle after frame", 32'(line_idle), 1);
        pulse(1);
        check("R9 idle cleared", 32'(line_idle), 0);
        wait_bits(12);
        check("R9 idle not re-armed", 32'(line_idle), 0);

        // R1: short glitch
        rx_in = 1'b0;
        repeat (BIT / 4) @(negedge clk);
        rx_in = 1'b1;
        wait_bits(12);
        check("R1 glitch stores nothing", 32'(data_rdy), 0);

        // R3: low stop bit
        send(8'hA5, 1'b0);
        wait_bits(12);
        check("R3 bad stop no data", 32'(data_rdy), 0);
        check("R3 bad stop no overrun", 32'(overrun), 0);
        check("R3 bad stop no idle", 32'(line_idle), 0);

        // R5 .. R10: overrun sequence on a two-entry buffer
        send(8'h11, 1'b1);
        wait_bits(1);
        send(8'h22, 1'b1);
        wait_bits(12);
        check("R9 idle before overrun", 32'(line_idle), 1);
        check("R5 no overrun when fitting", 32'(overrun), 0);
        send(8'h33, 1'b1);
        wait_bits(2);
        check("R5 overrun set on full", 32'(overrun), 1);
        check("R8 data_rdy kept", 32'(data_rdy), 1);
        check("R8 line_idle kept", 32'(line_idle), 1);
        check("R4 first in order", 32'(rd_data), 32'h11);
        pulse(0);
        check("R4 second in order", 32'(rd_data), 32'h22);
        pulse(0);
        check("R5 lost word not stored", 32'(data_rdy), 0);
        send(8'h44, 1'b1);
        wait_bits(2);
        check("R6 no store during overrun", 32'(data_rdy), 0);
        check("R6 overrun stays", 32'(overrun), 1);
        pulse(1);
        check("R9 clear idle", 32'(line_idle), 0);
        send(8'h55, 1'b1);
        wait_bits(12);
        check("R7 idle gated in overrun", 32'(line_idle), 0);
        check("R7 data_rdy gated in overrun", 32'(data_rdy), 0);
        pulse(2);
        check("R10 overrun cleared", 32'(overrun), 0);
        send(8'h66, 1'b1);
        wait_bits(2);
        check("R10 word after clear stored", 32'(data_rdy), 1);
        check("R10 word after clear value", 32'(rd_data), 32'h66);
        pulse(0);
        wait_bits(12);
        check("R9 idle re-armed by stored word", 32'(line_idle), 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule